// File: doc/BRIEF.md
# Exception Entry Sequencer

This block runs the entry half of processor exception handling. It starts when the fault is detected and ends when fetch of the handler's first instruction begins. When the core raises a request in the idle state, the sequencer takes a snapshot of the request's type, the interrupt level, the faulting program counter, the status register, the supervisor stack pointer and the vector base. It then produces the new status register value. Next it finds the vector number. For most exception types this comes from a fixed mapping. For an interrupt it comes from an interrupt-acknowledge read whose address carries the level.

The sequencer then pushes a two-word frame onto the supervisor stack through a single request/acknowledge memory port. It reads the handler address from the vector table, hands the core the new stack pointer, and gives a one-cycle start pulse with the handler address. The core keeps the user stack pointer, which the frame never touches: the frame always goes on the supervisor stack, whatever the current mode is.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `memReq`, `srWe`, `sspWe` and `fetchStart` are all 0.
- R2: A request `excReq` seen at a clock edge while idle gives `busy`=1 and a single-cycle `srWe` pulse in the following cycle.
- R3: Status register layout: bit 15 is trace, bit 13 is supervisor, bit 12 is master, bits 10:8 are the interrupt mask. For every non-interrupt type, `srOut` is the captured status register with bit 13 set and bit 15 cleared, and all other bits unchanged.
- R4: For the interrupt type (code 7), `srOut` also clears bit 12 and loads bits 10:8 with the captured level.
- R5: Non-interrupt type codes map to vector numbers as follows: 0→2, 1→3, 2→4, 3→5, 4→8, 5→9, 6→32. No bus read is made to obtain them.
- R6: An interrupt first issues a read to `IACK_BASE` with the level in address bits 4:2. The vector number is bits 7:0 of the returned data.
- R7: Let the frame base be (captured SSP with bits 1:0 cleared) minus 8. The first write puts the faulting PC at base+4. The second write puts {2'b01, SSP[1:0], 4'b0000, vector[7:0], saved SR[15:0]} at base.
- R8: The frame is always built from `sspIn`, even when status bit 13 was 0. `sspOut` equals the frame base, and `sspWe` pulses in the same cycle as `fetchStart`.
- R9: The handler address is read from `vecBase` + 4×vector after both frame writes. `fetchStart` pulses for one cycle, in the cycle after that read's acknowledge, with `handlerPc` equal to the read data.
- R10: Once raised, `memReq` holds, with its address, write flag and write data unchanged, until a clock edge at which `memAck` is 1.
- R11: A request raised while `busy` is 1 is ignored. Only one `srWe` pulse occurs per entry, and the frame, vector and handler come from the request that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excReq | input | 1 | Exception request |
| excType | input | 3 | Exception type code (7 = interrupt) |
| irqLevel | input | 3 | Level of the pending interrupt |
| faultPc | input | 32 | Program counter to be saved |
| srIn | input | 16 | Current status register |
| sspIn | input | 32 | Current supervisor stack pointer |
| vecBase | input | 32 | Vector table base address |
| busy | output | 1 | Sequence in progress |
| srWe | output | 1 | Status register write strobe |
| srOut | output | 16 | New status register value |
| sspWe | output | 1 | Supervisor stack pointer write strobe |
| sspOut | output | 32 | New supervisor stack pointer |
| memReq | output | 1 | Bus transfer request |
| memWe | output | 1 | Bus transfer is a write |
| memAddr | output | 32 | Bus address |
| memWdata | output | 32 | Bus write data |
| memRdata | input | 32 | Bus read data, valid with memAck |
| memAck | input | 1 | Bus transfer completes at this edge |
| vectorNum | output | 8 | Vector number of the current entry |
| handlerPc | output | 32 | Handler address, valid with fetchStart |
| fetchStart | output | 1 | Start fetch of the handler |

## Verification
Every type code is driven once with directed values. Interrupts at levels 1 and 7 separate the acknowledge path and the mask load from the fixed mapping. The supervisor stack pointer is tried with all four low-bit patterns, which separates the aligned frame base from the format bits that record the offset. Randomized runs vary the status register, the mode bit, the bus acknowledge delay and the table contents, so address or data mix-ups cannot be hidden. A second request with different operands, injected mid-sequence, shows whether a busy request leaks into the frame or the status register.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SRUPD, ST_VECTOR, ST_IACK,
    ST_PUSHPC, ST_PUSHFMT, ST_FETCHVEC, ST_DONE
  } seqState_t;

  typedef enum logic [1:0] {
    ADDR_IACK, ADDR_PC, ADDR_FMT, ADDR_VEC
  } addrSel_t;

  typedef struct packed {
    logic     capture;
    logic     srWr;
    logic     vecFixed;
    logic     vecIack;
    logic     handlerLoad;
    logic     memReq;
    logic     memWe;
    addrSel_t addrSel;
    logic     finish;
  } seqStrobe_t;

  localparam logic [2:0] EXC_IRQ = 3'd7;
  localparam int SR_T_BIT = 15;
  localparam int SR_S_BIT = 13;
  localparam int SR_M_BIT = 12;
  localparam int SR_MASK_LO = 8;

  function automatic logic [7:0] fixedVector(input logic [2:0] code);
    case (code)
      3'd0:    return 8'd2;
      3'd1:    return 8'd3;
      3'd2:    return 8'd4;
      3'd3:    return 8'd5;
      3'd4:    return 8'd8;
      3'd5:    return 8'd9;
      3'd6:    return 8'd32;
      default: return 8'd24;
    endcase
  endfunction

endpackage

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_entry_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       excReq,
  input  logic       isIrq,
  input  logic       memAck,
  output seqStrobe_t stb,
  output logic       busy
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb = '0;
    stb.addrSel = ADDR_PC;
    case (state)
      ST_IDLE: if (excReq) begin
        stb.capture = 1'b1;
        nextState = ST_SRUPD;
      end
      ST_SRUPD: begin
        stb.srWr = 1'b1;
        nextState = isIrq ? ST_IACK : ST_VECTOR;
      end
      ST_VECTOR: begin
        stb.vecFixed = 1'b1;
        nextState = ST_PUSHPC;
      end
      ST_IACK: begin
        stb.memReq = 1'b1;
        stb.addrSel = ADDR_IACK;
        if (memAck) begin
          stb.vecIack = 1'b1;
          nextState = ST_PUSHPC;
        end
      end
      ST_PUSHPC: begin
        stb.memReq = 1'b1;
        stb.memWe = 1'b1;
        stb.addrSel = ADDR_PC;
        if (memAck) nextState = ST_PUSHFMT;
      end
      ST_PUSHFMT: begin
        stb.memReq = 1'b1;
        stb.memWe = 1'b1;
        stb.addrSel = ADDR_FMT;
        if (memAck) nextState = ST_FETCHVEC;
      end
      ST_FETCHVEC: begin
        stb.memReq = 1'b1;
        stb.addrSel = ADDR_VEC;
        if (memAck) begin
          stb.handlerLoad = 1'b1;
          nextState = ST_DONE;
        end
      end
      ST_DONE: begin
        stb.finish = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  // R11
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(excReq));

  // R9
  finish_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |=> !busy);

endmodule

// File: rtl/exc_seq_dpath.sv
module exc_seq_dpath
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SR_W = 16,
  parameter int VEC_W = 8,
  parameter int LEVEL_W = 3,
  parameter logic [ADDR_W-1:0] IACK_BASE = 32'hFFFF_FFE0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [2:0]        excType,
  input  logic [LEVEL_W-1:0] irqLevel,
  input  logic [ADDR_W-1:0] faultPc,
  input  logic [SR_W-1:0]   srIn,
  input  logic [ADDR_W-1:0] sspIn,
  input  logic [ADDR_W-1:0] vecBase,
  input  logic [DATA_W-1:0] memRdata,
  output logic              isIrq,
  output logic [SR_W-1:0]   srOut,
  output logic [ADDR_W-1:0] sspOut,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [VEC_W-1:0]  vectorNum,
  output logic [ADDR_W-1:0] handlerPc
);

  localparam int FRAME_BYTES = 8;
  localparam int FMT_PAD = DATA_W - 4 - VEC_W - SR_W;
  localparam int VEC_PAD = ADDR_W - VEC_W - 2;
  localparam int LVL_PAD = ADDR_W - LEVEL_W - 2;

  logic [2:0]         typeQ;
  logic [LEVEL_W-1:0] levelQ;
  logic [ADDR_W-1:0]  pcQ, sspQ, vbrQ, handlerQ;
  logic [SR_W-1:0]    srSaved;
  logic [VEC_W-1:0]   vecQ;
  logic [ADDR_W-1:0]  frameBase;
  logic [DATA_W-1:0]  fmtWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      typeQ <= '0; levelQ <= '0; pcQ <= '0; sspQ <= '0;
      vbrQ <= '0; srSaved <= '0; vecQ <= '0; handlerQ <= '0;
    end else begin
      if (stb.capture) begin
        typeQ <= excType;
        levelQ <= irqLevel;
        pcQ <= faultPc;
        srSaved <= srIn;
        sspQ <= sspIn;
        vbrQ <= vecBase;
      end
      if (stb.vecFixed) vecQ <= fixedVector(typeQ);
      if (stb.vecIack)  vecQ <= memRdata[VEC_W-1:0];
      if (stb.handlerLoad) handlerQ <= memRdata;
    end
  end

  assign isIrq = (typeQ == EXC_IRQ);

  always_comb begin
    srOut = srSaved;
    srOut[SR_S_BIT] = 1'b1;
    srOut[SR_T_BIT] = 1'b0;
    if (isIrq) begin
      srOut[SR_M_BIT] = 1'b0;
      srOut[SR_MASK_LO +: LEVEL_W] = levelQ;
    end
  end

  assign frameBase = {sspQ[ADDR_W-1:2], 2'b00} - ADDR_W'(FRAME_BYTES);
  assign fmtWord = {2'b01, sspQ[1:0], {FMT_PAD{1'b0}}, vecQ, srSaved};

  always_comb begin
    case (stb.addrSel)
      ADDR_IACK: memAddr = IACK_BASE | {{LVL_PAD{1'b0}}, levelQ, 2'b00};
      ADDR_PC:   memAddr = frameBase + ADDR_W'(4);
      ADDR_FMT:  memAddr = frameBase;
      default:   memAddr = vbrQ + {{VEC_PAD{1'b0}}, vecQ, 2'b00};
    endcase
  end

  assign memWdata = (stb.addrSel == ADDR_PC) ? pcQ : fmtWord;
  assign sspOut = frameBase;
  assign vectorNum = vecQ;
  assign handlerPc = handlerQ;

  // R7
  frame_below_sp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.memReq && stb.memWe) |-> (memAddr[1:0] == 2'b00 && memAddr < sspQ));

  // R3
  sr_super_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.srWr |-> (srOut[SR_S_BIT] && !srOut[SR_T_BIT]));

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SR_W = 16,
  parameter int VEC_W = 8,
  parameter int LEVEL_W = 3,
  parameter logic [ADDR_W-1:0] IACK_BASE = 32'hFFFF_FFE0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excReq,
  input  logic [2:0]        excType,
  input  logic [LEVEL_W-1:0] irqLevel,
  input  logic [ADDR_W-1:0] faultPc,
  input  logic [SR_W-1:0]   srIn,
  input  logic [ADDR_W-1:0] sspIn,
  input  logic [ADDR_W-1:0] vecBase,
  output logic              busy,
  output logic              srWe,
  output logic [SR_W-1:0]   srOut,
  output logic              sspWe,
  output logic [ADDR_W-1:0] sspOut,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck,
  output logic [VEC_W-1:0]  vectorNum,
  output logic [ADDR_W-1:0] handlerPc,
  output logic              fetchStart
);

  seqStrobe_t stb;
  logic isIrq;

  exc_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .excReq(excReq), .isIrq(isIrq),
    .memAck(memAck), .stb(stb), .busy(busy)
  );

  exc_seq_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SR_W(SR_W), .VEC_W(VEC_W),
    .LEVEL_W(LEVEL_W), .IACK_BASE(IACK_BASE)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .excType(excType),
    .irqLevel(irqLevel), .faultPc(faultPc), .srIn(srIn), .sspIn(sspIn),
    .vecBase(vecBase), .memRdata(memRdata), .isIrq(isIrq), .srOut(srOut),
    .sspOut(sspOut), .memAddr(memAddr), .memWdata(memWdata),
    .vectorNum(vectorNum), .handlerPc(handlerPc)
  );

  assign srWe = stb.srWr;
  assign sspWe = stb.finish;
  assign fetchStart = stb.finish;
  assign memReq = stb.memReq;
  assign memWe = stb.memWe;

  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)
                             && $stable(memWdata)));

  // R9
  handler_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchStart |-> $past(memReq && !memWe && memAck));

endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;

  localparam logic [31:0] IACK_BASE = 32'hFFFF_FFE0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic excReq = 1'b0;
  logic [2:0] excType = '0, irqLevel = '0;
  logic [31:0] faultPc = '0, sspIn = '0, vecBase = '0;
  logic [15:0] srIn = '0;
  logic busy, srWe, sspWe, memReq, memWe, fetchStart;
  logic [15:0] srOut;
  logic [31:0] sspOut, memAddr, memWdata, handlerPc;
  logic [31:0] memRdata = '0;
  logic memAck = 1'b0;
  logic [7:0] vectorNum;

  always #5 clk = ~clk;

  exc_entry_seq #(.IACK_BASE(IACK_BASE)) u_dut (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excType(excType),
    .irqLevel(irqLevel), .faultPc(faultPc), .srIn(srIn), .sspIn(sspIn),
    .vecBase(vecBase), .busy(busy), .srWe(srWe), .srOut(srOut),
    .sspWe(sspWe), .sspOut(sspOut), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memAck(memAck), .vectorNum(vectorNum), .handlerPc(handlerPc),
    .fetchStart(fetchStart)
  );

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] tableWord(input logic [31:0] a);
    return {a[15:0] ^ 16'h3C5A, ~a[15:0]};
  endfunction

  function automatic logic [7:0] expVector(input logic [2:0] t);
    case (t)
      3'd0: return 8'd2;  3'd1: return 8'd3;  3'd2: return 8'd4;
      3'd3: return 8'd5;  3'd4: return 8'd8;  3'd5: return 8'd9;
      default: return 8'd32;
    endcase
  endfunction

  function automatic logic [15:0] expSr(input logic [15:0] s, input logic [2:0] t,
                                        input logic [2:0] lvl);
    logic [15:0] r;
    r = s;
    r[13] = 1'b1;
    r[15] = 1'b0;
    if (t == 3'd7) begin
      r[12] = 1'b0;
      r[10:8] = lvl;
    end
    return r;
  endfunction

  // bus model and monitor, active on the falling edge
  logic [31:0] logAddr[4];
  logic [31:0] logData[4];
  logic logWe[4];
  int logCnt = 0;
  int srWeCnt = 0;
  logic [15:0] srSeen;
  bit doneSeen = 0;
  logic [31:0] hpcSeen, spSeen;
  logic spWeSeen;
  int waitCnt = 0;
  logic [7:0] tbIrqVec = '0;
  bit pending = 0;
  logic [31:0] reqAddr, reqData;
  logic reqWe;

  always @(negedge clk) begin
    cycles++;
    if (srWe) begin srWeCnt++; srSeen = srOut; end
    if (fetchStart) begin
      doneSeen = 1; hpcSeen = handlerPc; spSeen = sspOut; spWeSeen = sspWe;
    end
    if (memAck) begin
      memAck = 1'b0;
      pending = 0;
    end else if (memReq) begin
      if (!pending) begin
        pending = 1; reqAddr = memAddr; reqWe = memWe; reqData = memWdata;
      end
      if (waitCnt == 0) begin
        // R10: request fields held since it was first raised
        chk(memAddr == reqAddr && memWe == reqWe && (!memWe || memWdata == reqData),
            "R10", memAddr, reqAddr);
        if (logCnt < 4) begin
          logAddr[logCnt] = memAddr; logData[logCnt] = memWdata;
          logWe[logCnt] = memWe; logCnt++;
        end
        if (!memWe) begin
          if (memAddr[31:5] == IACK_BASE[31:5])
            memRdata = {$urandom_range(0, 16'hFFFF), 8'h00, tbIrqVec};
          else memRdata = tableWord(memAddr);
        end
        memAck = 1'b1;
        waitCnt = $urandom_range(0, 3);
      end else waitCnt--;
    end
  end

  task automatic runExc(input logic [2:0] t, input logic [2:0] lvl,
                        input logic [31:0] pc, input logic [15:0] sr,
                        input logic [31:0] ssp, input logic [31:0] vbr,
                        input logic [7:0] ivec, input bit poke);
    logic [31:0] base, expFmt;
    logic [7:0] vec;
    int idx;
    int guard;
    @(negedge clk);
    logCnt = 0; srWeCnt = 0; doneSeen = 0; tbIrqVec = ivec;
    excReq = 1'b1; excType = t; irqLevel = lvl; faultPc = pc;
    srIn = sr; sspIn = ssp; vecBase = vbr;
    @(negedge clk);
    excReq = 1'b0;
    // R2
    chk(busy === 1'b1 && srWe === 1'b1, "R2", {30'd0, busy, srWe}, 32'd3);
    if (poke) begin
      @(negedge clk);
      excReq = 1'b1; excType = t ^ 3'd1; faultPc = ~pc; sspIn = ssp + 32'h100;
      srIn = ~sr; vecBase = vbr + 32'h40; irqLevel = ~lvl;
      @(negedge clk);
      @(negedge clk);
      excReq = 1'b0;
    end
    guard = 0;
    while (!doneSeen && guard < 300) begin @(negedge clk); guard++; end
    vec = (t == 3'd7) ? ivec : expVector(t);
    base = {ssp[31:2], 2'b00} - 32'd8;
    expFmt = {2'b01, ssp[1:0], 4'b0000, vec, sr};
    chk(doneSeen, "R9", {31'd0, doneSeen}, 32'd1);
    chk(srSeen == expSr(sr, t, lvl), (t == 3'd7) ? "R4" : "R3",
        {16'd0, srSeen}, {16'd0, expSr(sr, t, lvl)});
    idx = 0;
    if (t == 3'd7) begin
      chk(logCnt == 4 && !logWe[0] && logAddr[0] == (IACK_BASE | {27'd0, lvl, 2'b00}),
          "R6", logAddr[0], IACK_BASE | {27'd0, lvl, 2'b00});
      idx = 1;
    end else begin
      // R5: only writes and the table read appear on the bus
      chk(logCnt == 3, "R5", logCnt, 3);
    end
    chk(logWe[idx] && logAddr[idx] == base + 32'd4 && logData[idx] == pc,
        "R7", logData[idx], pc);
    chk(logWe[idx+1] && logAddr[idx+1] == base && logData[idx+1] == expFmt,
        "R7", logData[idx+1], expFmt);
    chk(vectorNum == vec, (t == 3'd7) ? "R6" : "R5", {24'd0, vectorNum}, {24'd0, vec});
    chk(!logWe[idx+2] && logAddr[idx+2] == vbr + {22'd0, vec, 2'b00},
        "R9", logAddr[idx+2], vbr + {22'd0, vec, 2'b00});
    chk(hpcSeen == tableWord(vbr + {22'd0, vec, 2'b00}), "R9", hpcSeen,
        tableWord(vbr + {22'd0, vec, 2'b00}));
    chk(spWeSeen && spSeen == base, "R8", spSeen, base);
    @(negedge clk);
    @(negedge clk);
    // R11: exactly one status write, and idle afterwards
    chk(srWeCnt == 1 && busy === 1'b0, "R11", srWeCnt, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1
    chk(busy === 1'b0 && memReq === 1'b0 && srWe === 1'b0 && sspWe === 1'b0
        && fetchStart === 1'b0, "R1",
        {27'd0, busy, memReq, srWe, sspWe, fetchStart}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && memReq === 1'b0, "R1", {30'd0, busy, memReq}, 32'd0);
    // directed: every type code, all stack pointer alignments
    for (int t = 0; t < 7; t++)
      runExc(3'(t), 3'd0, 32'h0000_1000 + 32'(t * 4), 16'hA71F,
             32'h0002_0000 + 32'(t % 4), 32'h0000_0400, 8'h00, 0);
    runExc(3'd7, 3'd1, 32'h0000_2222, 16'h2700, 32'h0003_0003, 32'h0000_0800, 8'h41, 0);
    runExc(3'd7, 3'd7, 32'h0000_3333, 16'h9000, 32'h0003_0001, 32'h0000_0C00, 8'hFF, 0);
    // R8: user-mode status (bit 13 clear)
    runExc(3'd2, 3'd0, 32'h0000_4444, 16'h0000, 32'h0004_0002, 32'h0000_0000, 8'h00, 0);
    // R11: request raised while busy
    runExc(3'd1, 3'd0, 32'h0000_5555, 16'h8000, 32'h0005_0000, 32'h0000_1000, 8'h00, 1);
    runExc(3'd7, 3'd4, 32'h0000_6666, 16'hB3FF, 32'h0006_0002, 32'h0000_1400, 8'h64, 1);
    // randomized
    for (int i = 0; i < 40; i++)
      runExc(3'($urandom_range(0, 7)), 3'($urandom_range(1, 7)), $urandom,
             16'($urandom), 32'h0010_0000 + 32'($urandom_range(0, 16'hFFFF)),
             $urandom & 32'h00FF_FC00, 8'($urandom_range(64, 255)),
             ($urandom_range(0, 3) == 0));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule